// File: doc/BRIEF.md
# Bit-Plane Routing Matrix

The block moves single bits from sixteen source shift registers to sixteen destination shift registers over one shared bus bit. A routing cycle works like this. A 4-bit source address picks one source register, and that register's most significant bit goes onto the bus. The bus bit is then shifted into the destination register that a latched 4-bit destination address selects. The sources are held in two banks of eight. The top bit of the source address selects the bank and switches the other bank off, so only one register ever drives the bus.

Source registers advance one bit position only after sixteen routing cycles, which is one full sweep. The bus can therefore visit every source at one bit position before the next position appears. With this ordering a whole bit-plane can be gathered into one destination register. For example, if sweep `s` is routed into destination `s`, the bit matrix is transposed. An inhibit input stops any destination from taking the bus bit. The block raises a one-cycle pulse when a sweep ends, and a sticky flag once a full source word has been swept out.

Top module: `bitplane_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, all source words, all destination words, the sweep counters and the latched destination address are cleared. After that, `sweep_done`, `done` and `bus_bit` read 0.
- R2: A cycle with `load_en` high writes source word i from `load_data[i*8 +: 8]`. It clears the routing-cycle count, the sweep count and `done`. It suppresses routing for that cycle, even if `route_en` is high.
- R3: `bus_bit` is bit 7 (the MSB) of the current word of the source selected by `src_addr`. It is combinational from the address and the register state.
- R4: `src_addr[3]` = 0 selects sources 0–7 and 1 selects sources 8–15, with `src_addr[2:0]` picking within the bank. Exactly one bank drives the bus in every cycle.
- R5: When `strobe` is high, `dst_addr` addresses the destination in that same cycle and is stored. When `strobe` is low, the stored address is used and `dst_addr` is ignored.
- R6: In a routing cycle (`route_en` high, `load_en` low, `inhibit` low), the addressed 16-bit destination word shifts left and takes `bus_bit` into bit 0. All other destination words keep their value. Word k appears at `out_data[k*16 +: 16]`.
- R7: When `inhibit` is high, no destination word changes. The routing cycle still counts toward the sweep.
- R8: On the 16th routing cycle since the last load or sweep end, every source word shifts left by one and a 0 enters bit 0. `sweep_done` is high for exactly the following cycle.
- R9: `done` rises together with the 8th `sweep_done` pulse. It stays high until a load or a reset.
- R10: Over eight sweeps with source address = cycle index and destination = sweep index s, destination s ends holding bit (7−s) of sources 0..15. Source 0 sits in bit 15 and source 15 in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Parallel load of all source words |
| load_data | input | 128 | Source words, word i at bits i*8+7..i*8 |
| route_en | input | 1 | Perform a routing cycle |
| src_addr | input | 4 | Source register select |
| dst_addr | input | 4 | Destination register select |
| strobe | input | 1 | Latch enable for the destination address |
| inhibit | input | 1 | Block all destination updates |
| bus_bit | output | 1 | Current shared bus bit |
| out_data | output | 256 | Destination words, word k at bits k*16+15..k*16 |
| sweep_done | output | 1 | One-cycle pulse after a source shift |
| done | output | 1 | Sticky flag after eight sweeps |

## Verification
The assertions assume that reset is applied at time zero and held across at least one clock edge. Their reference copy of `out_data` is only meaningful after that first edge. They also assume the bus is the only path into the destinations, so at most one destination word changes per cycle. The stimulus starts every scenario from a reset, and drives all inputs only on the falling edge, which keeps the sampled state defined. The stimulus visits every source address, every destination sweep index and both bank settings. It also covers inhibited sweeps, a load arriving mid-sweep and a load that coincides with a routing request.

// File: rtl/router_pkg.sv
// Shared constants for the bit-plane routing matrix.
// Assumes the source count is a power of two split into equal banks.
package router_pkg;
    localparam int DEF_WORD_W    = 8;
    localparam int DEF_BANK_SIZE = 8;
    localparam int DEF_N_BANKS   = 2;

    // Per-cycle routing control as seen by the datapath
    typedef struct packed {
        logic act;      // routing cycle takes effect
        logic blocked;  // destinations must hold
    } route_ctl_t;
endpackage

// File: rtl/src_bank.sv
// One bank of source shift registers with its bit selector.
// Words shift MSB-first; a disabled bank outputs 0 and does not drive.
// Assumes load has priority over shift.
module src_bank #(
    parameter int WORD_W    = 8,
    parameter int BANK_SIZE = 8,
    localparam int SEL_W    = $clog2(BANK_SIZE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_en,
    input  logic [BANK_SIZE*WORD_W-1:0] load_words,
    input  logic                        shift_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic                        bank_off,
    output logic                        bit_out,
    output logic                        driving
);
    logic [WORD_W-1:0] word_q [BANK_SIZE];

    // Load, shift or hold every word of the bank
    always_ff @(posedge clk) begin
        for (int i = 0; i < BANK_SIZE; i++) begin
            if (!rst_n)
                word_q[i] <= '0;
            else if (load_en)
                word_q[i] <= load_words[i*WORD_W +: WORD_W];
            else if (shift_en)
                word_q[i] <= {word_q[i][WORD_W-2:0], 1'b0};
        end
    end

    // Present the selected word's MSB when this bank is enabled
    always_comb begin
        driving = !bank_off;
        bit_out = bank_off ? 1'b0 : word_q[sel][WORD_W-1];
    end
endmodule

// File: rtl/sweep_ctrl.sv
// Counts routing cycles per sweep and sweeps per word.
// Issues the source shift on the last cycle of a sweep, a registered
// sweep-complete pulse, and a sticky done flag after WORD_W sweeps.
module sweep_ctrl #(
    parameter int N_SRC  = 16,
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(N_SRC),
    localparam int SWP_W = $clog2(WORD_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_en,
    input  logic route_act,
    output logic src_shift,
    output logic sweep_done,
    output logic done
);
    logic [CNT_W-1:0] cyc_q;
    logic [SWP_W-1:0] swp_q;

    // Shift sources when the last routing cycle of a sweep happens
    always_comb src_shift = route_act && (cyc_q == CNT_W'(N_SRC - 1));

    // Advance cycle and sweep counters and the flags
    always_ff @(posedge clk) begin
        if (!rst_n || load_en) begin
            cyc_q      <= '0;
            swp_q      <= '0;
            sweep_done <= 1'b0;
            done       <= 1'b0;
        end else begin
            sweep_done <= src_shift;
            if (route_act)
                cyc_q <= src_shift ? '0 : cyc_q + 1'b1;
            if (src_shift && !done) begin
                swp_q <= swp_q + 1'b1;
                if (swp_q == SWP_W'(WORD_W - 1))
                    done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dst_decoder.sv
// Destination address latch and 1-of-N line decoder.
// The latch is transparent while strobe is high; inhibit clears all lines.
module dst_decoder #(
    parameter int DST_AW = 4,
    localparam int N_DST = 2 ** DST_AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strobe,
    input  logic [DST_AW-1:0]       dst_addr,
    input  router_pkg::route_ctl_t  ctl,
    output logic [N_DST-1:0]        lines
);
    logic [DST_AW-1:0] lat_q;
    logic [DST_AW-1:0] eff;

    // Hold the destination address captured under strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= '0;
        else if (strobe)
            lat_q <= dst_addr;
    end

    // Decode the effective address into one active line
    always_comb begin
        eff   = strobe ? dst_addr : lat_q;
        lines = (ctl.act && !ctl.blocked) ? (N_DST'(1) << eff) : '0;
    end
endmodule

// File: rtl/dst_array.sv
// Destination shift registers; a word shifts in the bus bit at its LSB
// only when its decoded line is active.
module dst_array #(
    parameter int N_DST = 16,
    parameter int OUT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_DST-1:0]       lines,
    input  logic                   bus_bit,
    output logic [N_DST*OUT_W-1:0] out_data
);
    for (genvar k = 0; k < N_DST; k++) begin : g_dst
        logic [OUT_W-1:0] word_q;

        // Shift the bus bit into this word when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (lines[k])
                word_q <= {word_q[OUT_W-2:0], bus_bit};
        end

        assign out_data[k*OUT_W +: OUT_W] = word_q;
    end
endmodule

// File: rtl/bitplane_router.sv
// Top of the bit-plane routing matrix: banked source selection onto a
// single bus bit, sweep sequencing, and decoded destination shifting.
// Assumes N_BANKS >= 2 and BANK_SIZE a power of two.
module bitplane_router #(
    parameter int WORD_W    = router_pkg::DEF_WORD_W,
    parameter int BANK_SIZE = router_pkg::DEF_BANK_SIZE,
    parameter int N_BANKS   = router_pkg::DEF_N_BANKS,
    localparam int N_SRC    = BANK_SIZE * N_BANKS,
    localparam int SRC_AW   = $clog2(N_SRC),
    localparam int SEL_W    = $clog2(BANK_SIZE),
    localparam int BANK_IW  = $clog2(N_BANKS),
    localparam int DST_AW   = SRC_AW,
    localparam int N_DST    = 2 ** DST_AW,
    localparam int OUT_W    = N_SRC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [N_SRC*WORD_W-1:0] load_data,
    input  logic                    route_en,
    input  logic [SRC_AW-1:0]       src_addr,
    input  logic [DST_AW-1:0]       dst_addr,
    input  logic                    strobe,
    input  logic                    inhibit,
    output logic                    bus_bit,
    output logic [N_DST*OUT_W-1:0]  out_data,
    output logic                    sweep_done,
    output logic                    done
);
    router_pkg::route_ctl_t ctl;
    logic [N_BANKS-1:0] bank_bit;
    logic [N_BANKS-1:0] bank_drive;
    logic [BANK_IW-1:0] bank_idx;
    logic               src_shift;
    logic [N_DST-1:0]   dst_lines;

    // Form routing control; a load cycle suppresses routing
    always_comb begin
        ctl.act     = route_en && !load_en;
        ctl.blocked = inhibit;
        bank_idx    = src_addr[SRC_AW-1 -: BANK_IW];
    end

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        src_bank #(.WORD_W(WORD_W), .BANK_SIZE(BANK_SIZE)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (load_en),
            .load_words(load_data[b*BANK_SIZE*WORD_W +: BANK_SIZE*WORD_W]),
            .shift_en  (src_shift),
            .sel       (src_addr[SEL_W-1:0]),
            .bank_off  (bank_idx != BANK_IW'(b)),
            .bit_out   (bank_bit[b]),
            .driving   (bank_drive[b])
        );
    end

    // Merge the bank outputs onto the shared bus bit
    always_comb bus_bit = |bank_bit;

    sweep_ctrl #(.N_SRC(N_SRC), .WORD_W(WORD_W)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .route_act (ctl.act),
        .src_shift (src_shift),
        .sweep_done(sweep_done),
        .done      (done)
    );

    dst_decoder #(.DST_AW(DST_AW)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe),
        .dst_addr(dst_addr),
        .ctl     (ctl),
        .lines   (dst_lines)
    );

    dst_array #(.N_DST(N_DST), .OUT_W(OUT_W)) u_dst (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (dst_lines),
        .bus_bit (bus_bit),
        .out_data(out_data)
    );
endmodule

// File: rtl/bitplane_router_chk.sv
// Property checker for the routing matrix, bound to every instance.
module bitplane_router_chk #(
    parameter int N_DST   = 16,
    parameter int OUT_W   = 16,
    parameter int N_BANKS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   route_en,
    input logic                   inhibit,
    input logic                   load_en,
    input logic [N_DST*OUT_W-1:0] out_data,
    input logic                   sweep_done,
    input logic                   done,
    input logic [N_BANKS-1:0]     bank_drive,
    input logic [N_DST-1:0]       dst_lines
);
    logic [N_DST*OUT_W-1:0] prev_q;
    logic [N_DST-1:0]       chg;

    // Keep last cycle's destination contents
    always_ff @(posedge clk) prev_q <= out_data;

    // Flag destination words that changed since last cycle
    always_comb
        for (int k = 0; k < N_DST; k++)
            chg[k] = out_data[k*OUT_W +: OUT_W] != prev_q[k*OUT_W +: OUT_W];

    a_r4_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_drive) == 1);
    a_r6_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dst_lines));
    a_r6_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(chg) <= 1);
    a_r7_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && route_en) |=> $stable(out_data));
    a_r8_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);
    a_r9_rise_on_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> sweep_done);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load_en) |=> done);
endmodule

bind bitplane_router bitplane_router_chk #(
    .N_DST(N_DST), .OUT_W(OUT_W), .N_BANKS(N_BANKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .route_en(route_en), .inhibit(inhibit),
    .load_en(load_en), .out_data(out_data), .sweep_done(sweep_done),
    .done(done), .bank_drive(bank_drive), .dst_lines(dst_lines)
);

// File: tb/sim_bitplane_router.sv
`timescale 1ns/1ps
module sim_bitplane_router;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [127:0] load_data = '0;
    logic         route_en = 1'b0;
    logic [3:0]   src_addr = '0;
    logic [3:0]   dst_addr = '0;
    logic         strobe = 1'b0;
    logic         inhibit = 1'b0;
    logic         bus_bit;
    logic [255:0] out_data;
    logic         sweep_done;
    logic         done;

    int checks = 0;
    int errors = 0;

    // reference state derived from the requirements
    logic [7:0]  src_m [16];
    logic [15:0] out_m [16];
    logic [7:0]  ld_w  [16];
    int          cnt_m, swp_m;
    logic        done_m, sd_m;
    logic [3:0]  lat_m;

    always #4 clk = ~clk;

    bitplane_router u0 (.*);

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin src_m[i] = '0; out_m[i] = '0; end
        cnt_m = 0; swp_m = 0; done_m = 0; sd_m = 0; lat_m = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; load_en = 0; route_en = 0; strobe = 0; inhibit = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic compare_all(input string req);
        logic [255:0] exp;
        for (int k = 0; k < 16; k++) exp[k*16 +: 16] = out_m[k];
        chk(req, out_data, exp);
        chk("R8 sweep_done", 256'(sweep_done), 256'(sd_m));
        chk("R9 done", 256'(done), 256'(done_m));
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic do_cycle(input logic ld, input logic rt, input logic [3:0] s,
                            input logic [3:0] d, input logic stb, input logic inh);
        logic [3:0] eff;
        logic b;
        load_en = ld; route_en = rt; src_addr = s; dst_addr = d; strobe = stb; inhibit = inh;
        for (int i = 0; i < 16; i++) load_data[i*8 +: 8] = ld_w[i];
        #1;
        if (rt && !ld) chk("R3 bus bit", 256'(bus_bit), 256'(src_m[s][7]));
        @(posedge clk);
        eff = stb ? d : lat_m;
        b = src_m[s][7];
        if (ld) begin
            for (int i = 0; i < 16; i++) src_m[i] = ld_w[i];
            cnt_m = 0; swp_m = 0; done_m = 0; sd_m = 0;
        end else if (rt) begin
            if (!inh) out_m[eff] = {out_m[eff][14:0], b};
            if (cnt_m == 15) begin
                for (int i = 0; i < 16; i++) src_m[i] = {src_m[i][6:0], 1'b0};
                cnt_m = 0; sd_m = 1;
                if (!done_m) begin swp_m++; if (swp_m == 8) done_m = 1; end
            end else begin
                cnt_m++; sd_m = 0;
            end
        end else sd_m = 0;
        if (stb) lat_m = d;
        @(negedge clk);
        load_en = 0; route_en = 0; strobe = 0; inhibit = 0;
        compare_all("R6 out_data");
    endtask

    task automatic set_words(input int mul, input int add);
        for (int i = 0; i < 16; i++) ld_w[i] = 8'((i * mul + add) & 255);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] snap;
        logic [15:0]  exp16;
        set_words(37, 11);
        model_reset();
        do_reset();
        // R1 reset state
        #1;
        chk("R1 out_data", out_data, '0);
        chk("R1 done", 256'(done), 0);
        chk("R1 sweep_done", 256'(sweep_done), 0);
        chk("R1 bus_bit", 256'(bus_bit), 0);

        // R2 load, then R3/R4 address map over every source
        do_cycle(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 16; i++) begin
            src_addr = 4'(i); #1;
            chk("R4 bank select", 256'(bus_bit), 256'(ld_w[i][7]));
        end

        // R10 transposition: sweep s into destination s
        for (int s = 0; s < 8; s++)
            for (int k = 0; k < 16; k++)
                do_cycle(0, 1, 4'(k), 4'(s), 1, 0);
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 16; k++)
                exp16[15-k] = (s < 8) ? ld_w[k][7-s] : 1'b0;
            chk("R10 transpose", 256'(out_data[s*16 +: 16]), 256'(exp16));
        end
        chk("R9 done after eight sweeps", 256'(done), 1);
        // R9 sticky through more routing, cleared by load
        for (int k = 0; k < 16; k++) do_cycle(0, 1, 4'(k), 4'(12), 1, 0);
        chk("R9 sticky", 256'(done), 1);
        do_cycle(1, 1, 4'(3), 4'(13), 1, 0);   // R2 load wins over routing
        chk("R2 load clears done", 256'(done), 0);

        // R5 strobe latch: capture 9, then ignore dst_addr=3
        do_reset();
        set_words(91, 200);
        do_cycle(1, 0, 0, 0, 0, 0);
        do_cycle(0, 0, 0, 4'(9), 1, 0);
        for (int k = 0; k < 16; k++) do_cycle(0, 1, 4'(k), 4'(3), 0, 0);
        for (int k = 0; k < 16; k++) exp16[15-k] = ld_w[k][7];
        chk("R5 latched destination", 256'(out_data[9*16 +: 16]), 256'(exp16));
        chk("R5 ignored destination", 256'(out_data[3*16 +: 16]), 0);

        // R7 inhibit: outputs hold, sweep still advances
        snap = out_data;
        for (int k = 0; k < 16; k++) do_cycle(0, 1, 4'(k), 4'(5), 1, 1);
        chk("R7 inhibit hold", out_data, snap);
        src_addr = 4'(0); #1;
        chk("R8 shifted under inhibit", 256'(bus_bit), 256'(ld_w[0][5]));

        // R2/R8 load mid-sweep restarts the cycle count
        for (int k = 0; k < 5; k++) do_cycle(0, 1, 4'(k), 4'(6), 1, 0);
        do_cycle(1, 0, 0, 0, 0, 0);
        for (int k = 0; k < 15; k++) do_cycle(0, 1, 4'(k), 4'(7), 1, 0);
        chk("R8 no early sweep", 256'(sweep_done), 0);
        do_cycle(0, 1, 4'(15), 4'(7), 1, 0);
        chk("R8 sweep pulse", 256'(sweep_done), 1);

        // R6 reversed pattern across both banks
        do_reset();
        set_words(53, 7);
        do_cycle(1, 0, 0, 0, 0, 0);
        for (int s = 0; s < 8; s++)
            for (int k = 0; k < 16; k++)
                do_cycle(0, 1, 4'(15 - k), 4'(15 - s), (k == 0), 0);
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 16; k++) exp16[k] = ld_w[k][7-s];
            chk("R6 reversed slices", 256'(out_data[(15-s)*16 +: 16]), 256'(exp16));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule